// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Power-Down

This block is a single-port synchronous memory built from four byte lanes. Each lane is 9 bits wide: 8 data bits and 1 parity bit. A sequencer presents one access per clock. It drives an access strobe, a word address, a write-data word and three write qualifiers: a global write, a byte-write enable and one enable per lane. All three qualifiers are active low. Writes complete at the clock edge where they are accepted. Reads are registered and appear on the data outputs in the following cycle. A drive flag stands in for the tri-state control of a bidirectional bus. An asynchronous output enable gates that flag.

A power-down input moves the block through a short entry phase into sleep. In sleep nothing is accepted, the outputs stay undriven and the stored words are kept. When the input falls, a short wake-up phase follows. Strobes that arrive during wake-up are discarded. A 2-bit status output reports the current power phase so that surrounding logic and benches can follow it.

Top module: `lane_sram`

## Requirements
- R1: With `glob_wr_n` low, an accepted access writes all four lanes of the addressed word, whatever `byte_wr_n` and `lane_wr_n` are.
- R2: With `glob_wr_n` high and `byte_wr_n` low, an accepted access writes exactly those lanes whose `lane_wr_n` bit is low. Lane k is bits [9k+8:9k] of the word, parity bit included, and the other lanes keep their contents.
- R3: With `glob_wr_n` high and either `byte_wr_n` high or all `lane_wr_n` bits high, the access is a read and the memory is left unchanged.
- R4: After an accepted read, `rdata` carries the addressed word in the next cycle. `rdata_en` is high in that cycle only while `oe_n` is low, and it follows `oe_n` without waiting for a clock.
- R5: In the cycle after an accepted write, or after a cycle with no accepted access, `rdata_en` is low.
- R6: With `pwr_dn` held high, the status shows 2'b01 (entering) for two cycles and then 2'b10 (sleep). Accesses are still served while the status is 2'b01.
- R7: While the status is 2'b10, strobes are ignored, `rdata_en` stays low and the memory contents are kept.
- R8: After `pwr_dn` returns low, the status shows 2'b11 (waking) for two cycles and strobes in those cycles are ignored. The status then returns to 2'b00 (normal) and the next strobe is accepted.
- R9: A read of an address in the cycle right after a write to that address returns the newly written data.
- R10: A synchronous `rst` puts the status at 2'b00 and `rdata_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe from the sequencer |
| addr | input | ADDR_W | Word address |
| glob_wr_n | input | 1 | Global write, active low, writes every lane |
| byte_wr_n | input | 1 | Byte-write enable, active low, qualifies `lane_wr_n` |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data, lane k at bits [9k+8:9k] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pwr_dn | input | 1 | Power-down request, active high (tie low when unused) |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_en | output | 1 | Output drive enable (low means high impedance) |
| pwr_status | output | 2 | 00 normal, 01 entering, 10 sleep, 11 waking |

## Verification
The bench first fills every address with global writes. For these writes the byte-write and lane inputs are set to values that would otherwise mask lanes, so reading the words back shows that the global write overrides them. Next, all sixteen lane-enable patterns are applied as byte writes to different words, each followed by a read. A lane that is written by mistake, or missed, shows up as a wrong 9-bit field. Qualifier combinations that should count as reads are then applied with fresh data on `wdata`, which would reveal a stray write. Further cases cover a write followed at once by a read of the same address, toggling of `oe_n` inside one cycle, and a full enter-sleep-wake sequence with strobes placed in sleep and in both wake-up cycles.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_ENTER = 2'b01,
    ST_SLEEP = 2'b10,
    ST_WAKE  = 2'b11
  } pwr_st_e;
endpackage

// File: rtl/lane_sram_wrq.sv
module lane_sram_wrq #(
  parameter int LANES = 4
) (
  input  logic             glob_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_sel
);
  // global write wins; byte writes need the byte-write qualifier
  always_comb begin
    if (!glob_wr_n)      lane_sel = '1;
    else if (!byte_wr_n) lane_sel = ~lane_wr_n;
    else                 lane_sel = '0;
  end
endmodule

// File: rtl/lane_sram_pwr.sv
module lane_sram_pwr
  import lane_sram_pkg::*;
#(
  parameter int PD_CYC = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pwr_dn,
  output pwr_st_e st,
  output logic    run_ok
);
  localparam int CW = (PD_CYC > 1) ? $clog2(PD_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PD_CYC - 1);

  pwr_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: if (pwr_dn) begin
          st_q  <= ST_ENTER;
          cnt_q <= '0;
        end
        ST_ENTER: begin
          if (!pwr_dn)                st_q  <= ST_RUN;
          else if (cnt_q == CNT_LAST) st_q  <= ST_SLEEP;
          else                        cnt_q <= cnt_q + 1'b1;
        end
        ST_SLEEP: if (!pwr_dn) begin
          st_q  <= ST_WAKE;
          cnt_q <= '0;
        end
        default: begin
          if (cnt_q == CNT_LAST) st_q  <= ST_RUN;
          else                   cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign st     = st_q;
  assign run_ok = (st_q == ST_RUN) || (st_q == ST_ENTER);

  assert_sleep_via_enter_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP && $past(st_q) != ST_SLEEP) |-> $past(st_q) == ST_ENTER);

  assert_wake_via_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAKE && $past(st_q) != ST_WAKE) |-> $past(st_q) == ST_SLEEP);
endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      if (re)    rd_q      <= mem[addr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int PD_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_vld,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    glob_wr_n,
  input  logic                    byte_wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    pwr_dn,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en,
  output logic [1:0]              pwr_status
);
  pwr_st_e          st;
  logic             run_ok;
  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] arr_we;
  logic             arr_re;
  logic             accept;
  logic             rd_live_q;

  lane_sram_pwr #(.PD_CYC(PD_CYC)) u_pwr (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .st(st), .run_ok(run_ok)
  );

  lane_sram_wrq #(.LANES(LANES)) u_wrq (
    .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n),
    .lane_wr_n(lane_wr_n), .lane_sel(lane_sel)
  );

  assign accept = acc_vld && run_ok;
  assign arr_we = accept ? lane_sel : '0;
  assign arr_re = accept && (lane_sel == '0);

  lane_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(addr), .we(arr_we), .re(arr_re),
    .wdata(wdata), .rdata(rdata)
  );

  // read data is live only in the cycle after an accepted read
  always_ff @(posedge clk) begin
    if (rst) rd_live_q <= 1'b0;
    else     rd_live_q <= arr_re;
  end

  assign rdata_en   = rd_live_q && !oe_n && (st != ST_SLEEP);
  assign pwr_status = st;

  assert_wr_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (arr_we != '0) |=> !rdata_en);

  assert_drive_needs_oe_R4: assert property (@(posedge clk) disable iff (rst)
    rdata_en |-> !oe_n);

  assert_wake_holdoff_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAKE) |-> (arr_we == '0 && !arr_re));

  assert_sleep_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLEEP) |-> (arr_we == '0 && !arr_re));
endmodule

// File: tb/lane_sram_bench.sv
module lane_sram_bench;
  localparam int CLK_PER = 10;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_vld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          glob_wr_n = 1'b1;
  logic          byte_wr_n = 1'b1;
  logic [LN-1:0] lane_wr_n = '1;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b0;
  logic          pwr_dn = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_en;
  logic [1:0]    pwr_status;

  logic [DW-1:0] mdl [DEPTH];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  lane_sram u_lane_sram (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .addr(addr),
    .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .wdata(wdata), .oe_n(oe_n), .pwr_dn(pwr_dn),
    .rdata(rdata), .rdata_en(rdata_en), .pwr_status(pwr_status)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    logic [DW-1:0] v;
    for (int l = 0; l < LN; l++) v[l*LW +: LW] = LW'(a * 7 + l * 13 + salt * 31 + 5);
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one access; writes update the model, reads compare data
  task automatic access(int a, bit gw, bit bw, logic [LN-1:0] ln, logic [DW-1:0] d, string req);
    logic [LN-1:0] m;
    logic [DW-1:0] e;
    m = !gw ? '1 : (!bw ? ~ln : '0);
    @(negedge clk);
    acc_vld = 1; addr = AW'(a); glob_wr_n = gw; byte_wr_n = bw; lane_wr_n = ln; wdata = d;
    e = mdl[a];
    for (int l = 0; l < LN; l++) if (m[l]) mdl[a][l*LW +: LW] = d[l*LW +: LW];
    @(negedge clk);
    acc_vld = 0;
    if (m == '0) chk(rdata_en && rdata == e, req, rdata, e);
    else         chk(!rdata_en, {req, "/R5"}, DW'(rdata_en), '0);
  endtask

  task automatic rd(int a, string req);
    access(a, 1'b1, 1'b1, '1, ~pat(a, 9), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(pwr_status == 2'b00 && !rdata_en, "R10", DW'({pwr_status, rdata_en}), '0);
    rst = 0;

    // R1 fill with global writes; masking qualifiers must not matter
    for (int a = 0; a < DEPTH; a++)
      access(a, 1'b0, a[0], LN'(a), pat(a, 1), "R1");
    for (int a = 0; a < DEPTH; a++) rd(a, "R1");

    // R2 all lane patterns as byte writes
    for (int m = 0; m < 16; m++) begin
      access(m, 1'b1, 1'b0, LN'(m), pat(m, 2), "R2");
      rd(m, "R2");
    end

    // R3 qualifier combinations that must read and leave memory alone
    access(20, 1'b1, 1'b1, 4'b0000, pat(20, 3), "R3");
    access(21, 1'b1, 1'b0, 4'b1111, pat(21, 3), "R3");
    rd(20, "R3");
    rd(21, "R3");

    // R4 asynchronous output enable within the data cycle
    @(negedge clk);
    acc_vld = 1; addr = 6'd30; glob_wr_n = 1; byte_wr_n = 1; oe_n = 1;
    @(negedge clk);
    acc_vld = 0;
    chk(!rdata_en, "R4", DW'(rdata_en), '0);
    oe_n = 0;
    #1;
    chk(rdata_en && rdata == mdl[30], "R4", rdata, mdl[30]);
    // R5 idle cycle after read
    @(negedge clk);
    chk(!rdata_en, "R5", DW'(rdata_en), '0);

    // R9 write then immediate read of the same address
    @(negedge clk);
    acc_vld = 1; addr = 6'd40; glob_wr_n = 0; wdata = pat(40, 7); mdl[40] = pat(40, 7);
    @(negedge clk);
    glob_wr_n = 1; byte_wr_n = 1;
    @(negedge clk);
    acc_vld = 0;
    chk(rdata_en && rdata == mdl[40], "R9", rdata, mdl[40]);

    // R6 sleep entry
    pwr_dn = 1;
    @(negedge clk);
    chk(pwr_status == 2'b01, "R6", DW'(pwr_status), 1);
    @(negedge clk);
    chk(pwr_status == 2'b01, "R6", DW'(pwr_status), 1);
    @(negedge clk);
    chk(pwr_status == 2'b10, "R6", DW'(pwr_status), 2);
    // R7 strobes in sleep
    acc_vld = 1; addr = 6'd3; glob_wr_n = 0; wdata = pat(3, 11);
    @(negedge clk);
    glob_wr_n = 1; byte_wr_n = 1;
    @(negedge clk);
    acc_vld = 0;
    chk(pwr_status == 2'b10 && !rdata_en, "R7", DW'({pwr_status, rdata_en}), 4);
    // R8 wake-up
    pwr_dn = 0;
    @(negedge clk);
    chk(pwr_status == 2'b11, "R8", DW'(pwr_status), 3);
    acc_vld = 1; addr = 6'd4; glob_wr_n = 0; wdata = pat(4, 12);
    @(negedge clk);
    chk(pwr_status == 2'b11, "R8", DW'(pwr_status), 3);
    addr = 6'd5; wdata = pat(5, 12);
    @(negedge clk);
    chk(pwr_status == 2'b00, "R8", DW'(pwr_status), 0);
    addr = 6'd4; glob_wr_n = 1; byte_wr_n = 1;
    @(negedge clk);
    acc_vld = 0;
    chk(rdata_en && rdata == mdl[4], "R8", rdata, mdl[4]);
    rd(3, "R7");
    rd(5, "R8");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule